// File: doc/BRIEF.md
# Overcurrent Cycle-Skipping PWM Limiter

This block sits between a per-phase PWM on-time request and the gate commands of a multiphase synchronous buck controller. At every switching-period tick it samples each phase's signed, digitized valley current reading. It then decides for each phase whether the period runs normally, runs with a clipped on-time, or is skipped entirely. A skipped period holds the low-side switch on.

The on-time request is first trimmed by a current-balance term. The trim pulls each phase toward the average of all phase readings. The trimmed value is then clipped to a maximum on-time. In variable mode that maximum falls linearly with the total measured current. In fixed mode it is a constant. When a phase's reading exceeds its overcurrent threshold, that phase produces no high-side pulse for the whole period. This repeats at every tick until the reading falls back. A per-phase flag marks every period that was skipped or clipped.

Top module: `ocl_skip_limiter`

## Requirements
- R1: After reset, and until the first period tick, `hs_en_o`, `ls_en_o` and `limit_o` are all 0 for every phase.
- R2: After a tick is sampled on a rising edge, a phase's high-side enable is 1 for exactly `ton` consecutive cycles starting right after that edge. From the first tick onward, `ls_en_o` is the complement of `hs_en_o` for that phase.
- R3: A phase whose signed reading is strictly greater than the threshold OC = NOM_LVL*OC_PCT/100 (1400 by default) at the tick is skipped for that period: high side off, low side on for the whole period, and the flag set. A reading equal to OC is not skipped.
- R4: At the next tick where the reading is at or below OC, the phase resumes normal pulses for that period.
- R5: Readings are two's complement, SW bits wide. A negative reading never triggers a skip. A negative total current counts as zero in the limit calculation.
- R6: The trimmed request is adj = req + ((avg - own) >>> BAL_SHIFT), where avg = floor(sum/NPHASE) over all readings and BAL_SHIFT defaults to 2.
- R7: With `fixed_mode_i` = 0, the limit is tmax = T_HI - ((T_HI - T_LO) * itot) / IMAX. Here T_HI = floor(PERIOD*80/100), T_LO = floor(PERIOD*40/100), IMAX = NPHASE*OC, and itot is the total reading clamped to [0, IMAX]. With defaults this gives 80 at zero load and 40 at IMAX = 2800.
- R8: With `fixed_mode_i` = 1, the limit is tmax = floor(PERIOD*FIX_PCT/100), which is 70 by default, for any current.
- R9: For a phase that is not skipped, ton = min(adj, tmax) when adj > 0 and 0 otherwise. A ton of 0 gives no high-side pulse in that period.
- R10: `limit_o` for a phase is updated only at a tick and is then held for the period. It becomes 1 when the phase is skipped or when adj > tmax, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| period_tick_i | input | 1 | One-cycle pulse that starts each switching period |
| fixed_mode_i | input | 1 | 1: constant on-time limit; 0: current-dependent limit |
| sense_i | input | NPHASE*SW | Per-phase signed valley current readings |
| ton_req_i | input | NPHASE*TW | Per-phase on-time request in clock cycles |
| hs_en_o | output | NPHASE | High-side switch enable per phase |
| ls_en_o | output | NPHASE | Low-side switch enable per phase |
| limit_o | output | NPHASE | Phase skipped or clipped in the current period |

## Verification
Several rules are checked on every cycle:
- the two switches of a phase are never on together;
- a high-side pulse starts only right after a tick;
- an over-threshold reading at a tick forces a skipped period with the flag set;
- the flag never moves between ticks;
- no pulse runs longer than the largest possible limit;
- all outputs stay idle before the first tick.

Other behaviour only the bench scenarios can show, because it depends on exact arithmetic across phases:
- the exact pulse width produced by the balance trim and the linear or fixed limit;
- the threshold boundary at exactly OC;
- recovery after consecutive skipped periods;
- the treatment of negative readings.

// File: rtl/ocl_pkg.sv
package ocl_pkg;
  // Clamp a signed value into [0, hi].
  function automatic int unsigned clamp_pos(input int v, input int unsigned hi);
    if (v < 0) return 0;
    if (int'(hi) < v) return hi;
    return int'(v);
  endfunction
endpackage

// File: rtl/ocl_sense_avg.sv
module ocl_sense_avg #(
  parameter int NPHASE = 2,
  parameter int SW     = 13,
  parameter int IMAX   = 2800,
  localparam int SUMW  = SW + $clog2(NPHASE),
  localparam int IW    = $clog2(IMAX + 1)
) (
  input  logic [NPHASE-1:0][SW-1:0] sense,
  output logic signed [SUMW-1:0]    avg,
  output logic [IW-1:0]             itot
);
  localparam int SH = $clog2(NPHASE);

  logic signed [SUMW-1:0] sum;

  always_comb begin
    sum = '0;
    for (int i = 0; i < NPHASE; i++) begin
      sum = sum + SUMW'($signed(sense[i]));
    end
  end

  // NPHASE is a power of two: arithmetic shift floors the mean.
  assign avg = sum >>> SH;

  always_comb begin
    if (sum < 0) begin
      itot = '0;
    end else if (sum > SUMW'(IMAX)) begin
      itot = IW'(IMAX);
    end else begin
      itot = IW'(sum);
    end
  end
endmodule

// File: rtl/ocl_ton_limit.sv
module ocl_ton_limit #(
  parameter int PERIOD     = 100,
  parameter int IMAX       = 2800,
  parameter int VAR_HI_PCT = 80,
  parameter int VAR_LO_PCT = 40,
  parameter int FIX_PCT    = 70,
  localparam int TW        = $clog2(PERIOD + 1),
  localparam int IW        = $clog2(IMAX + 1)
) (
  input  logic [IW-1:0] itot,
  input  logic          fixed_mode,
  output logic [TW-1:0] tmax
);
  localparam int T_HI  = PERIOD * VAR_HI_PCT / 100;
  localparam int T_LO  = PERIOD * VAR_LO_PCT / 100;
  localparam int T_FIX = PERIOD * FIX_PCT / 100;
  localparam int DT    = T_HI - T_LO;
  localparam int PW    = IW + TW;

  logic [PW-1:0] prod;
  logic [PW-1:0] quot;
  logic [TW-1:0] tvar;

  always_comb begin
    prod = PW'(DT) * PW'(itot);
    quot = prod / PW'(IMAX);
    tvar = TW'(T_HI) - TW'(quot);
  end

  generate
    if (T_FIX == T_HI) begin : g_same
      assign tmax = fixed_mode ? TW'(T_FIX) : tvar;
    end else begin : g_diff
      assign tmax = fixed_mode ? TW'(T_FIX) : tvar;
    end
  endgenerate
endmodule

// File: rtl/ocl_phase_gate.sv
module ocl_phase_gate #(
  parameter int SW        = 13,
  parameter int SUMW      = 14,
  parameter int TW        = 7,
  parameter int OC_LVL    = 1400,
  parameter int BAL_SHIFT = 2,
  localparam int AW       = SUMW + 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic [SW-1:0]          own,
  input  logic signed [SUMW-1:0] avg,
  input  logic [TW-1:0]          req,
  input  logic [TW-1:0]          tmax,
  output logic                   hs,
  output logic                   ls,
  output logic                   lim
);
  logic signed [AW-1:0] diff;
  logic signed [AW-1:0] adj;
  logic signed [AW-1:0] tmax_s;
  logic                 over;
  logic [TW-1:0]        ton_nx;
  logic                 lim_nx;

  logic [TW-1:0]        rem_q, rem_d;
  logic                 lim_q, lim_d;
  logic                 run_q, run_d;

  // Period decision, evaluated from the sampled inputs
  always_comb begin
    diff   = AW'(avg) - AW'($signed(own));
    adj    = $signed({{(AW-TW){1'b0}}, req}) + (diff >>> BAL_SHIFT);
    tmax_s = $signed({{(AW-TW){1'b0}}, tmax});
    over   = $signed(own) > SW'(OC_LVL);
    if (over) begin
      ton_nx = '0;
      lim_nx = 1'b1;
    end else if (adj <= 0) begin
      ton_nx = '0;
      lim_nx = 1'b0;
    end else if (adj > tmax_s) begin
      ton_nx = tmax;
      lim_nx = 1'b1;
    end else begin
      ton_nx = TW'(adj);
      lim_nx = 1'b0;
    end
  end

  // Next state
  always_comb begin
    rem_d = rem_q;
    lim_d = lim_q;
    run_d = run_q;
    if (tick) begin
      rem_d = ton_nx;
      lim_d = lim_nx;
      run_d = 1'b1;
    end else if (rem_q != '0) begin
      rem_d = rem_q - 1'b1;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      lim_q <= 1'b0;
      run_q <= 1'b0;
    end else begin
      rem_q <= rem_d;
      lim_q <= lim_d;
      run_q <= run_d;
    end
  end

  assign hs  = (rem_q != '0);
  assign ls  = run_q & ~hs;
  assign lim = lim_q;
endmodule

// File: rtl/ocl_skip_limiter.sv
module ocl_skip_limiter #(
  parameter int NPHASE     = 2,
  parameter int SW         = 13,
  parameter int PERIOD     = 100,
  parameter int NOM_LVL    = 1000,
  parameter int OC_PCT     = 140,
  parameter int VAR_HI_PCT = 80,
  parameter int VAR_LO_PCT = 40,
  parameter int FIX_PCT    = 70,
  parameter int BAL_SHIFT  = 2,
  localparam int TW        = $clog2(PERIOD + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      period_tick_i,
  input  logic                      fixed_mode_i,
  input  logic [NPHASE-1:0][SW-1:0] sense_i,
  input  logic [NPHASE-1:0][TW-1:0] ton_req_i,
  output logic [NPHASE-1:0]         hs_en_o,
  output logic [NPHASE-1:0]         ls_en_o,
  output logic [NPHASE-1:0]         limit_o
);
  localparam int OC_LVL = NOM_LVL * OC_PCT / 100;
  localparam int IMAX   = NPHASE * OC_LVL;
  localparam int SUMW   = SW + $clog2(NPHASE);
  localparam int IW     = $clog2(IMAX + 1);
  localparam int T_CAP  = PERIOD * ((VAR_HI_PCT > FIX_PCT) ? VAR_HI_PCT : FIX_PCT) / 100;

  // Reset synchronizer: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_q_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_q_n = rst_sync_q[1];

  logic signed [SUMW-1:0] avg;
  logic [IW-1:0]          itot;
  logic [TW-1:0]          tmax;

  ocl_sense_avg #(
    .NPHASE(NPHASE), .SW(SW), .IMAX(IMAX)
  ) u_avg (
    .sense(sense_i), .avg(avg), .itot(itot)
  );

  ocl_ton_limit #(
    .PERIOD(PERIOD), .IMAX(IMAX), .VAR_HI_PCT(VAR_HI_PCT),
    .VAR_LO_PCT(VAR_LO_PCT), .FIX_PCT(FIX_PCT)
  ) u_lim (
    .itot(itot), .fixed_mode(fixed_mode_i), .tmax(tmax)
  );

  generate
    for (genvar p = 0; p < NPHASE; p++) begin : g_ph
      ocl_phase_gate #(
        .SW(SW), .SUMW(SUMW), .TW(TW), .OC_LVL(OC_LVL), .BAL_SHIFT(BAL_SHIFT)
      ) u_gate (
        .clk (clk_i),
        .rst_n(rst_q_n),
        .tick(period_tick_i),
        .own (sense_i[p]),
        .avg (avg),
        .req (ton_req_i[p]),
        .tmax(tmax),
        .hs  (hs_en_o[p]),
        .ls  (ls_en_o[p]),
        .lim (limit_o[p])
      );
    end
  endgenerate
endmodule

// File: rtl/ocl_skip_limiter_chk.sv
module ocl_skip_limiter_chk #(
  parameter int NPHASE = 2,
  parameter int SW     = 13,
  parameter int TW     = 7,
  parameter int OC_LVL = 1400,
  parameter int T_CAP  = 80
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      tick,
  input logic [NPHASE-1:0][SW-1:0] sense,
  input logic [NPHASE-1:0]         hs,
  input logic [NPHASE-1:0]         ls,
  input logic [NPHASE-1:0]         lim
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else if (tick) seen_q <= 1'b1;
  end

  // R1: idle before the first tick
  a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> (hs == '0 && ls == '0 && lim == '0));

  generate
    for (genvar p = 0; p < NPHASE; p++) begin : g_chk
      logic [TW:0] run_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else if (hs[p] && run_q != '1) run_q <= run_q + 1'b1;
        else if (!hs[p]) run_q <= '0;
      end

      // R2: switches of one phase never on together
      a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs[p] && ls[p]));

      // R2: a high-side pulse begins only right after a tick
      a_r2_start_at_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs[p]) |-> $past(tick));

      // R3: reading above threshold forces a skipped, flagged period
      a_r3_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ($signed(sense[p]) > SW'(OC_LVL))) |=> (!hs[p] && ls[p] && lim[p]));

      // R10: flag changes only at a tick
      a_r10_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(lim[p]));

      // R9: pulse length never exceeds the largest limit
      a_r9_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= (TW+1)'(T_CAP));
    end
  endgenerate
endmodule

bind ocl_skip_limiter ocl_skip_limiter_chk #(
  .NPHASE(NPHASE), .SW(SW), .TW(TW), .OC_LVL(OC_LVL), .T_CAP(T_CAP)
) chk_i (
  .clk  (clk_i),
  .rst_n(rst_q_n),
  .tick (period_tick_i),
  .sense(sense_i),
  .hs   (hs_en_o),
  .ls   (ls_en_o),
  .lim  (limit_o)
);

// File: tb/ocl_skip_limiter_tb_top.sv
module ocl_skip_limiter_tb_top;
  localparam int PERIOD = 100;
  localparam int SW     = 13;
  localparam int TW     = 7;
  localparam int OC     = 1400;
  localparam int IMAX   = 2 * OC;
  localparam int T80    = PERIOD * 80 / 100;
  localparam int T40    = PERIOD * 40 / 100;
  localparam int TFIX   = PERIOD * 70 / 100;

  logic clk = 1'b0;
  logic rst_n;
  logic tick;
  logic fm;
  logic [1:0][SW-1:0] sense;
  logic [1:0][TW-1:0] req;
  logic [1:0] hs, ls, lim;

  always #2 clk = ~clk;

  ocl_skip_limiter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .period_tick_i(tick), .fixed_mode_i(fm),
    .sense_i(sense), .ton_req_i(req), .hs_en_o(hs), .ls_en_o(ls), .limit_o(lim)
  );

  typedef struct {
    int    ton0;
    int    ton1;
    bit    lim0;
    bit    lim1;
    string tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic void phase_model(input int own, input int avg, input int r,
                                      input int tmax, output int ton, output bit l);
    int adj;
    adj = r + ((avg - own) >>> 2);
    if (own > OC) begin ton = 0; l = 1'b1; end
    else if (adj <= 0) begin ton = 0; l = 1'b0; end
    else if (adj > tmax) begin ton = tmax; l = 1'b1; end
    else begin ton = adj; l = 1'b0; end
  endfunction

  task automatic run_period(input int s0, input int s1, input int r0, input int r1,
                            input bit mode, input string tag);
    exp_t e;
    int sum, avg, itot, tmax;
    sum  = s0 + s1;
    avg  = sum >>> 1;
    itot = (sum < 0) ? 0 : ((sum > IMAX) ? IMAX : sum);
    tmax = mode ? TFIX : (T80 - ((T80 - T40) * itot) / IMAX);
    phase_model(s0, avg, r0, tmax, e.ton0, e.lim0);
    phase_model(s1, avg, r1, tmax, e.ton1, e.lim1);
    e.tag = tag;
    @(negedge clk);
    sense[0] = SW'(s0); sense[1] = SW'(s1);
    req[0] = TW'(r0); req[1] = TW'(r1);
    fm = mode;
    tick = 1'b1;
    q.push_back(e);
    @(negedge clk);
    tick = 1'b0;
    repeat (PERIOD - 1) @(negedge clk);
  endtask

  // Monitor: measure each period's pulse and compare with the queue head
  int  cnt[2];
  int  lsbad[2];
  bit  lim_s[2];
  bit  active = 1'b0;

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (tick) begin
        if (active && q.size() > 0) begin
          exp_t e;
          e = q.pop_front();
          check({e.tag, " ph0 ton"}, cnt[0], e.ton0);
          check({e.tag, " ph1 ton"}, cnt[1], e.ton1);
          check({e.tag, " ph0 flag R10"}, int'(lim_s[0]), int'(e.lim0));
          check({e.tag, " ph1 flag R10"}, int'(lim_s[1]), int'(e.lim1));
          check({e.tag, " R2 complement"}, lsbad[0] + lsbad[1], 0);
        end
        cnt = '{0, 0};
        lsbad = '{0, 0};
        lim_s[0] = lim[0];
        lim_s[1] = lim[1];
        active = 1'b1;
      end
      if (active) begin
        for (int p = 0; p < 2; p++) begin
          if (hs[p]) cnt[p]++;
          if (ls[p] == hs[p]) lsbad[p]++;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    tick = 1'b0;
    fm = 1'b0;
    sense = '0;
    req = '0;
    repeat (3) @(negedge clk);
    check("R1 reset hs", int'(hs), 0);
    check("R1 reset ls", int'(ls), 0);
    rst_n = 1'b1;
    sense[0] = SW'(2000);
    req[0] = TW'(50);
    repeat (6) @(negedge clk);
    check("R1 pre-tick hs", int'(hs), 0);
    check("R1 pre-tick ls", int'(ls), 0);
    check("R1 pre-tick flag", int'(lim), 0);

    run_period(500, 500, 30, 30, 1'b0, "R2 R7 balanced");
    run_period(500, 500, 0, 0, 1'b0, "R9 zero request");
    run_period(800, 400, 60, 60, 1'b0, "R6 R10 imbalance");
    run_period(1500, 1000, 30, 30, 1'b0, "R3 overcurrent");
    run_period(1600, 1000, 30, 30, 1'b0, "R3 skip again");
    run_period(1000, 1000, 30, 30, 1'b0, "R4 recovery");
    run_period(1400, 1400, 50, 50, 1'b0, "R3 R7 at threshold");
    run_period(1401, 1399, 50, 50, 1'b0, "R3 R9 just above");
    run_period(-300, -500, 20, 20, 1'b0, "R5 R9 negative");
    run_period(-4000, 200, 30, 30, 1'b0, "R5 R6 deep negative");
    run_period(1000, 1000, 75, 75, 1'b1, "R8 fixed clip");
    run_period(1400, 1400, 60, 60, 1'b1, "R8 fixed full load");
    run_period(1400, 1600, 10, 10, 1'b0, "R7 R3 total clamp");
    run_period(700, 700, 79, 79, 1'b0, "R7 mid load");

    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 queue drained", q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule